// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Error-Signal Repeat

This block sends one byte at a time to a smart card over a single shared, open-drain I/O line, using the half-duplex character protocol in which the receiver reports a bad character during the guard time. Each bit lasts one elementary time unit (ETU). The ETU is a whole number of card-clock cycles, given by the divisor input and captured when a byte is written. A character is a low start bit, then the eight data bits with the least significant bit first, then a parity bit, then two guard periods. During the guard periods the transmitter does not drive the line.

The receiver may hold the line low during the first guard period to reject the character. The transmitter samples the line in the middle of that period. A low sample sets a sticky error flag and adds one bit period to the character. The transmitter then sends the same byte again, starting from a new start bit. A retry cap, captured at write time, limits how many times a character is repeated. When a character is rejected after the cap has been used, it is dropped and the error flag stays set. Software writes a byte with a one-cycle strobe when the ready flag is high. It clears the error flag with a one-cycle clear strobe.

Top module: `sc_t0_tx`

## Requirements
- R1: After reset, ready_o is 1, err_o is 0 and drive_low_o is 0 (line released).
- R2: A wr_i pulse while ready_o is 1 captures data_i, etu_div_i and retry_cap_i. On the next cycle ready_o is 0 and the start bit begins, with drive_low_o at 1 for exactly etu_div_i clock cycles. etu_div_i must be at least 4.
- R3: The eight data bits follow the start bit, bit 0 first. Each lasts one ETU. drive_low_o is 1 for a 0 bit and 0 for a 1 bit.
- R4: The tenth bit is a parity bit that makes the number of ones in the data bits plus the parity bit even.
- R5: After the parity bit, drive_low_o stays 0 for the whole guard time. line_i passes through a two-stage synchronizer and is sampled in clock cycle etu_div_i/2 (rounded down) of the first guard period. A low sample is a rejection.
- R6: If the character is not rejected, ready_o returns to 1 exactly 12 ETUs after the cycle in which the write was accepted.
- R7: A rejection sets err_o. The guard time then lasts three ETUs, and the same byte is sent again with its start bit beginning 13 ETUs after the start of the rejected attempt.
- R8: A character is repeated at most retry_cap_i times. A rejection of the last allowed attempt drops the character and returns ready_o to 1, 13 ETUs after that attempt began. err_o stays 1.
- R9: err_o stays 1 until an err_clr_i pulse in a cycle with no new rejection clears it. It is only ever set by a rejection sampled in the guard time.
- R10: A wr_i pulse while ready_o is 0 is ignored. The character in flight is unchanged, and no further character is sent afterwards.
- R11: drive_low_o changes only at ETU boundaries and at the start of a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| etu_div_i | input | 16 | Clock cycles per ETU, captured on write (at least 4) |
| retry_cap_i | input | 4 | Maximum number of repeats, captured on write |
| data_i | input | 8 | Byte to send |
| wr_i | input | 1 | Write strobe, accepted when ready_o is 1 |
| err_clr_i | input | 1 | Clears err_o |
| line_i | input | 1 | Level seen on the shared I/O line |
| drive_low_o | output | 1 | 1 = pull the I/O line low |
| ready_o | output | 1 | Idle and able to accept a byte |
| err_o | output | 1 | Sticky flag: a character was rejected |

## Verification
The checker asserts on every cycle the properties that hold locally: the line is released while idle and during the guard time, a write starts a low start bit, the drive level and ready flag are stable between ETU boundaries, and the error flag is sticky and is set only in the guard time. Other behaviour needs whole characters to show. This covers bit order and parity, the 12- and 13-ETU character lengths, the repeat of the same byte after a rejection, the drop at the retry cap and the ignored busy writes. The bench checks these by modelling a card that rejects chosen attempts and comparing every cycle of the line against a frame it builds itself.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_GUARD = 2'd2
  } tx_state_e;
endpackage

// File: rtl/sc_sync2.sv
module sc_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int ETU_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [ETU_W-1:0] div_i,
  output logic             bit_end_o,
  output logic             mid_o
);
  logic [ETU_W-1:0] cnt_q;

  assign bit_end_o = run_i && (cnt_q == div_i - 1'b1);
  assign mid_o     = run_i && (cnt_q == (div_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || bit_end_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sc_tx_frame.sv
module sc_tx_frame #(
  parameter int DATA_W  = 8,
  localparam int FRAME_W = DATA_W + 2,
  localparam int IDX_W   = $clog2(FRAME_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);
  // frame: bit 0 start, then data LSB first, then even parity
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_q <= '1;
    else if (load_i) frame_q <= {^data_i, data_i, 1'b0};
  end

  assign bit_o = frame_q[idx_i];
endmodule

// File: rtl/sc_t0_ctrl.sv
module sc_t0_ctrl
  import sc_t0_pkg::*;
#(
  parameter int FRAME_W = 10,
  parameter int RETRY_W = 4,
  localparam int IDX_W  = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               clr_i,
  input  logic [RETRY_W-1:0] cap_i,
  input  logic               bit_end_i,
  input  logic               mid_i,
  input  logic               line_s_i,
  output tx_state_e          state_o,
  output logic [IDX_W-1:0]   bit_idx_o,
  output logic               load_o,
  output logic               err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  tx_state_e          state_q;
  logic [IDX_W-1:0]   bit_idx_q;
  logic [1:0]         g_idx_q;
  logic               nack_q;
  logic [RETRY_W-1:0] cap_q, retries_q;
  logic               err_q;
  logic               nack_seen;
  logic [1:0]         g_last;

  assign load_o    = (state_q == ST_IDLE) && wr_i;
  assign nack_seen = (state_q == ST_GUARD) && mid_i && (g_idx_q == 2'd0) && !line_s_i;
  // a rejection stretches the guard time by one ETU
  assign g_last    = nack_q ? 2'd2 : 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_idx_q <= '0;
      g_idx_q   <= '0;
      nack_q    <= 1'b0;
      cap_q     <= '0;
      retries_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_i) begin
            state_q   <= ST_SEND;
            bit_idx_q <= '0;
            retries_q <= '0;
            cap_q     <= cap_i;
          end
        end
        ST_SEND: begin
          if (bit_end_i) begin
            if (bit_idx_q == LAST_IDX) begin
              state_q <= ST_GUARD;
              g_idx_q <= '0;
              nack_q  <= 1'b0;
            end else begin
              bit_idx_q <= bit_idx_q + 1'b1;
            end
          end
        end
        ST_GUARD: begin
          if (nack_seen) nack_q <= 1'b1;
          if (bit_end_i) begin
            if (g_idx_q == g_last) begin
              if (!nack_q || retries_q == cap_q) begin
                state_q <= ST_IDLE;
              end else begin
                retries_q <= retries_q + 1'b1;
                state_q   <= ST_SEND;
                bit_idx_q <= '0;
              end
            end else begin
              g_idx_q <= g_idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (nack_seen) err_q <= 1'b1;
    else if (clr_i)     err_q <= 1'b0;
  end

  assign state_o   = state_q;
  assign bit_idx_o = bit_idx_q;
  assign err_o     = err_q;
endmodule

// File: rtl/sc_t0_tx.sv
module sc_t0_tx
  import sc_t0_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ETU_W   = 16,
  parameter int RETRY_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ETU_W-1:0]   etu_div_i,
  input  logic [RETRY_W-1:0] retry_cap_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               wr_i,
  input  logic               err_clr_i,
  input  logic               line_i,
  output logic               drive_low_o,
  output logic               ready_o,
  output logic               err_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  tx_state_e        state;
  logic [IDX_W-1:0] bit_idx;
  logic             load, bit_end, mid, line_s, frame_bit, in_guard;
  logic [ETU_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= ETU_W'(4);
    else if (load) div_q <= etu_div_i;
  end

  sc_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  sc_etu_timer #(.ETU_W(ETU_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state != ST_IDLE),
    .div_i    (div_q),
    .bit_end_o(bit_end),
    .mid_o    (mid)
  );

  sc_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .data_i(data_i),
    .idx_i (bit_idx),
    .bit_o (frame_bit)
  );

  sc_t0_ctrl #(.FRAME_W(FRAME_W), .RETRY_W(RETRY_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .clr_i    (err_clr_i),
    .cap_i    (retry_cap_i),
    .bit_end_i(bit_end),
    .mid_i    (mid),
    .line_s_i (line_s),
    .state_o  (state),
    .bit_idx_o(bit_idx),
    .load_o   (load),
    .err_o    (err_o)
  );

  assign in_guard    = (state == ST_GUARD);
  assign drive_low_o = (state == ST_SEND) && !frame_bit;
  assign ready_o     = (state == ST_IDLE);
endmodule

// File: rtl/sc_t0_tx_chk.sv
module sc_t0_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic err_clr_i,
  input logic drive_low_o,
  input logic ready_o,
  input logic err_o,
  input logic bit_end_i,
  input logic in_guard_i
);
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_i) |=> (drive_low_o && !ready_o));

  a_r5_guard_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_guard_i |-> !drive_low_o);

  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !drive_low_o);

  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !bit_end_i) |=> !ready_o);

  a_r11_bit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !bit_end_i) |=> $stable(drive_low_o));

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);

  a_r9_err_from_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(in_guard_i));
endmodule

bind sc_t0_tx sc_t0_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .err_clr_i  (err_clr_i),
  .drive_low_o(drive_low_o),
  .ready_o    (ready_o),
  .err_o      (err_o),
  .bit_end_i  (bit_end),
  .in_guard_i (in_guard)
);

// File: tb/sc_t0_tx_test.sv
module sc_t0_tx_test;
  localparam int ETU_W = 16, RETRY_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ETU_W-1:0] etu_div = 16'd4;
  logic [RETRY_W-1:0] cap = '0;
  logic [7:0] data = '0;
  logic wr = 1'b0, clr = 1'b0, card_low = 1'b0;
  logic line, drive_low, ready, err;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  assign line = !(drive_low || card_low);

  sc_t0_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .etu_div_i(etu_div), .retry_cap_i(cap),
    .data_i(data), .wr_i(wr), .err_clr_i(clr), .line_i(line),
    .drive_low_o(drive_low), .ready_o(ready), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit frame_bit(input logic [7:0] d, input int b);
    if (b == 0) return 1'b0;
    if (b <= 8) return d[b-1];
    return ^d;
  endfunction

  task automatic run_char(input logic [7:0] d, input int div, input int cp,
                          input int nacks, input bit busy_wr);
    @(negedge clk);
    etu_div = ETU_W'(div);
    cap = RETRY_W'(cp);
    data = d;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    data = ~d;
    etu_div = 16'd7;
    cap = '1;
    for (int a = 0; a <= cp; a++) begin
      bit nk;
      int len;
      nk = (a < nacks);
      len = nk ? 13 * div : 12 * div;
      for (int k = 0; k < len; k++) begin
        if (k < 10 * div) begin
          int b;
          b = k / div;
          if (b == 0)      chk(drive_low == 1'b1, "R2 start bit", drive_low, 1);
          else if (b < 9)  chk(drive_low == !frame_bit(d, b), "R3 data bit", drive_low, !frame_bit(d, b));
          else             chk(drive_low == !frame_bit(d, b), "R4 parity bit", drive_low, !frame_bit(d, b));
        end else begin
          chk(drive_low == 1'b0, "R5 guard released", drive_low, 0);
        end
        chk(ready == 1'b0, "R11 busy until end", ready, 0);
        if (nk && k == 12 * div) chk(err == 1'b1, "R7 err set", err, 1);
        if (busy_wr && a == 0 && (k == div + 1 || k == 11 * div)) begin
          wr = 1'b1;  // R10 busy write
        end else begin
          wr = 1'b0;
        end
        card_low = nk && (k >= 10 * div - 1) && (k < 11 * div - 1);
        @(negedge clk);
      end
      card_low = 1'b0;
      wr = 1'b0;
      if (!nk) break;
    end
    if (nacks > cp) chk(ready == 1'b1, "R8 dropped at cap", ready, 1);
    else            chk(ready == 1'b1, "R6 ready after guard", ready, 1);
    chk(err == (nacks > 0), "R7 err flag", err, nacks > 0);
    if (busy_wr) begin
      for (int k = 0; k < 13 * div; k++) begin
        chk(ready == 1'b1 && drive_low == 1'b0, "R10 no extra char", drive_low, 0);
        @(negedge clk);
      end
    end
    if (err) begin
      repeat (3) @(negedge clk);
      chk(err == 1'b1, "R9 err held", err, 1);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      chk(err == 1'b0, "R9 err cleared", err, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0071));
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 ready at reset", ready, 1);
    chk(err == 1'b0, "R1 err at reset", err, 0);
    chk(drive_low == 1'b0, "R1 line released", drive_low, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_char(8'h00, 4, 2, 0, 1'b0);
    run_char(8'hFF, 5, 1, 0, 1'b0);
    run_char(8'hA5, 6, 2, 1, 1'b0);
    run_char(8'h3C, 8, 0, 1, 1'b0);
    run_char(8'h5A, 4, 1, 3, 1'b0);
    run_char(8'h81, 5, 3, 3, 1'b0);
    run_char(8'h6E, 6, 1, 1, 1'b1);
    for (int i = 0; i < 16; i++) begin
      run_char(8'($urandom), 4 + int'($urandom % 7), int'($urandom % 4),
               int'($urandom % 5), 1'($urandom % 2));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule